// File: doc/BRIEF.md
# Audio Frame-Clock Ratio Checker

This block measures how many master-clock cycles pass between consecutive rising edges of the audio frame clock, which sets the sample rate. It then decides whether that count is one of the integer ratios permitted for the selected speed range. The frame clock is brought into the master-clock domain through a synchronizer chain. Its rising edge is detected there, and every full period is timed by a saturating counter.

Each measurement produces three results. The first is a ratio code, which is the position of the count in the ascending list of legal ratios for the current speed range. The second is a stability flag, raised when two successive periods have the same length. The third is an error flag, raised for an illegal or changing ratio.

A separate divide control input permits the largest ratio of each range. It is also forwarded, one cycle later, as an enable for halving the internal master clock. Downstream logic uses the flags to hold off its data path until the clocking is stable and legal.

Top module: `audio_ratio_checker`

## Requirements
- R1: While the synchronous active-low reset is low, and in the first cycle after it, the ratio code is 7, the stable flag is 0, the error flag is 0 and the divide enable is 0.
- R2: With speed select 0 (single), a period of 256, 384, 512 or 768 master-clock cycles gives code 0, 1, 2 or 3 respectively, with no error.
- R3: With speed select 1 (double), a period of 128, 192, 256 or 384 cycles gives code 0, 1, 2 or 3.
- R4: With speed select 2 (quad), a period of 128 or 192 cycles gives code 0 or 1, and a period of 384 or longer is illegal (code 7).
- R5: The top ratio of each range (1024 as code 4 for single, 512 as code 4 for double, 256 as code 2 for quad) is legal only while the divide control is 1. With the control at 0, that period gives code 7 and sets the error flag.
- R6: The first measurement after reset only arms the checker and leaves the outputs unchanged. The stable flag is 1 only when the current period equals the previous measured period.
- R7: A measured period that differs from the previous one clears the stable flag and sets the error flag for that measurement.
- R8: A period that is not in the table of the selected range gives code 7 and sets the error flag.
- R9: Speed select 3 is reserved. Every period then gives code 7 with the error flag set.
- R10: The divide enable output equals the divide control input of the previous cycle.
- R11: The period counter saturates at 4095. Any period of 4096 cycles or more is measured as 4096, which is illegal. Two such periods in a row still count as stable.
- R12: Only rising edges of the frame clock start and end a period. The high time of the frame clock has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| frame_clk_i | input | 1 | Frame clock, asynchronous to clk_i sampling |
| speed_sel_i | input | 2 | 0 single, 1 double, 2 quad, 3 reserved |
| half_rate_i | input | 1 | Divide control; permits the top ratio |
| ratio_code_o | output | 3 | Index into the legal-ratio list, 7 when illegal |
| ratio_stable_o | output | 1 | Two successive periods measured equal |
| ratio_err_o | output | 1 | Illegal ratio or period change |
| clk_div_en_o | output | 1 | Enable for halving the internal master clock |

## Verification
A corrupted period counter or arming flag shows up as a wrong code or a wrong stable flag. This appears three master-clock cycles after the frame-clock rising edge that closes the affected period. Stored-previous-period faults show up one measurement later, as a spurious error or a missing stable indication. Table or permission faults show up directly on the code at the same three-cycle point. This is why each frame is checked shortly after its rising edge, across every speed range, both settings of the divide control, and the saturating case.

// File: rtl/arc_pkg.sv
// Package: shared types and constants for the frame-clock ratio checker.
// Assumes a 3-bit ratio code with one reserved value marking illegal ratios.
package arc_pkg;

    typedef enum logic [1:0] {
        SPEED_SINGLE = 2'd0,
        SPEED_DOUBLE = 2'd1,
        SPEED_QUAD   = 2'd2,
        SPEED_RSVD   = 2'd3
    } speed_e;

    localparam int unsigned CODE_W      = 3;
    localparam logic [2:0]  CODE_BAD    = 3'd7;
    localparam int unsigned NUM_RATIOS  = 5;

    // Ratio multipliers in units of half the base ratio: 1, 1.5, 2, 3, 4.
    function automatic int unsigned ratio_mult(input int unsigned idx);
        case (idx)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/arc_edge_sync.sv
// Module: brings the frame clock into the master-clock domain and emits a
// one-cycle pulse per rising edge. Assumes the frame clock is slow compared
// to clk_i (at least several cycles high and low).
module arc_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // First synchronizer stage samples the raw input.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
    end

    // Remaining stages form the metastability chain.
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
        end
    end

    // Edge-detect history register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

    p_rise_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o)
        else $error("rise pulse longer than one cycle");

endmodule

// File: rtl/arc_period_counter.sv
// Module: counts master-clock cycles between rising-edge pulses and reports
// the closed period length with a strobe. Assumes rise pulses are single
// cycles. The first pulse after reset only arms the counter.
module arc_period_counter #(
    parameter int unsigned CNT_W = 12,
    localparam int unsigned PER_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic             strobe_o,
    output logic [PER_W-1:0] period_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Saturating cycle counter, restarted on every rising edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (rise_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign period_o = {1'b0, cnt_q} + PER_W'(1);
    assign strobe_o = rise_i & armed_q;

    p_cnt_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> (cnt_q == '0))
        else $error("counter not restarted on edge");

    p_cnt_saturate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && !rise_i) |=> (cnt_q == CNT_MAX))
        else $error("counter wrapped");

    p_first_edge_arms_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(armed_q) |-> !$past(strobe_o))
        else $error("strobe before arming");

endmodule

// File: rtl/arc_ratio_lookup.sv
// Module: maps a period length to its index in the legal-ratio list of the
// selected speed range. The top entry of each range needs the divide control.
// Purely combinational; the clock is used only by the assertions.
module arc_ratio_lookup
    import arc_pkg::*;
#(
    parameter int unsigned PER_W       = 13,
    parameter int unsigned BASE_SINGLE = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PER_W-1:0] period_i,
    input  logic [1:0]       speed_sel_i,
    input  logic             half_rate_i,
    output logic [2:0]       code_o
);

    localparam logic [PER_W-1:0] HALF_SINGLE = PER_W'(BASE_SINGLE / 2);
    localparam logic [PER_W-1:0] HALF_FAST   = PER_W'(BASE_SINGLE / 4);

    logic [PER_W-1:0]      base_half;
    logic [2:0]            top_idx;
    logic                  range_ok;
    logic [NUM_RATIOS-1:0] hit;

    // Select the base ratio and the highest table index for the range.
    always_comb begin
        base_half = HALF_FAST;
        top_idx   = 3'd4;
        range_ok  = 1'b1;
        case (speed_e'(speed_sel_i))
            SPEED_SINGLE: base_half = HALF_SINGLE;
            SPEED_DOUBLE: base_half = HALF_FAST;
            SPEED_QUAD:   top_idx   = 3'd2;
            default:      range_ok  = 1'b0;
        endcase
    end

    // One comparator per table entry.
    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_entry
        localparam logic [2:0]       IDX  = 3'(i);
        localparam logic [PER_W-1:0] MULT = PER_W'(ratio_mult(i));
        logic [PER_W-1:0] entry_val;
        logic             allowed;
        assign entry_val = base_half * MULT;
        assign allowed   = range_ok &&
                           ((IDX < top_idx) || (IDX == top_idx && half_rate_i));
        assign hit[i]    = allowed && (period_i == entry_val);
    end

    // Encode the matching entry, or mark the ratio illegal.
    always_comb begin
        code_o = CODE_BAD;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) code_o = 3'(i);
        end
    end

    p_single_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit))
        else $error("several table entries matched");

    p_top_needs_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!half_rate_i && code_o != CODE_BAD) |-> (code_o < top_idx))
        else $error("top ratio accepted without divide control");

    p_rsvd_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (speed_sel_i == 2'd3) |-> (code_o == CODE_BAD))
        else $error("reserved range produced a legal code");

endmodule

// File: rtl/arc_verdict.sv
// Module: registers the ratio code and judges stability against the previous
// measured period. Assumes one strobe per closed period.
module arc_verdict
    import arc_pkg::*;
#(
    parameter int unsigned PER_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [2:0]       code_i,
    output logic [2:0]       code_o,
    output logic             stable_o,
    output logic             err_o
);

    logic [PER_W-1:0] prev_q;
    logic             have_prev_q;
    logic             same_len;

    assign same_len = have_prev_q && (period_i == prev_q);

    // Update the verdict and remember the period on each measurement.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            code_o      <= CODE_BAD;
            stable_o    <= 1'b0;
            err_o       <= 1'b0;
        end else if (strobe_i) begin
            prev_q      <= period_i;
            have_prev_q <= 1'b1;
            code_o      <= code_i;
            stable_o    <= same_len;
            err_o       <= (code_i == CODE_BAD) || (have_prev_q && !same_len);
        end
    end

    p_stable_needs_repeat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stable_o) |-> $past(strobe_i))
        else $error("stable raised without a measurement");

    p_change_flags_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && have_prev_q && period_i != prev_q) |=> (err_o && !stable_o))
        else $error("period change not flagged");

    p_bad_code_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && code_i == CODE_BAD) |=> err_o)
        else $error("illegal ratio not flagged");

    p_hold_between_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |=> ($stable(code_o) && $stable(stable_o) && $stable(err_o)))
        else $error("verdict changed without a measurement");

endmodule

// File: rtl/audio_ratio_checker.sv
// Module: top of the frame-clock ratio checker. It synchronizes the frame
// clock, times each period, looks it up in the table of the selected speed
// range and reports code, stability and error. It also forwards the divide
// control as a registered enable.
module audio_ratio_checker
    import arc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned BASE_SINGLE = 256
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       frame_clk_i,
    input  logic [1:0] speed_sel_i,
    input  logic       half_rate_i,
    output logic [2:0] ratio_code_o,
    output logic       ratio_stable_o,
    output logic       ratio_err_o,
    output logic       clk_div_en_o
);

    localparam int unsigned PER_W = CNT_W + 1;

    logic             rise;
    logic             strobe;
    logic [PER_W-1:0] period;
    logic [2:0]       code_now;

    arc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (frame_clk_i),
        .rise_o  (rise)
    );

    arc_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise),
        .strobe_o (strobe),
        .period_o (period)
    );

    arc_ratio_lookup #(.PER_W(PER_W), .BASE_SINGLE(BASE_SINGLE)) u_lookup (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .period_i    (period),
        .speed_sel_i (speed_sel_i),
        .half_rate_i (half_rate_i),
        .code_o      (code_now)
    );

    arc_verdict #(.PER_W(PER_W)) u_verdict (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe),
        .period_i (period),
        .code_i   (code_now),
        .code_o   (ratio_code_o),
        .stable_o (ratio_stable_o),
        .err_o    (ratio_err_o)
    );

    // Forward the divide control as a registered enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) clk_div_en_o <= 1'b0;
        else         clk_div_en_o <= half_rate_i;
    end

    p_div_follow_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_rate_i |=> clk_div_en_o)
        else $error("divide enable not raised");

    p_div_follow_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !half_rate_i |=> !clk_div_en_o)
        else $error("divide enable not cleared");

endmodule

// File: tb/sim_audio_ratio_checker.sv
module sim_audio_ratio_checker;

    typedef struct {
        logic [2:0] code;
        logic       stable;
        logic       err;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic [1:0] speed = 2'd0;
    logic       half = 1'b0;
    logic [2:0] code;
    logic       stable;
    logic       err;
    logic       div_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // Reference model state
    bit         armed = 1'b0;
    bit         have_prev = 1'b0;
    int         prev_n = 0;
    int         last_len = 0;
    logic [2:0] e_code = 3'd7;
    logic       e_stable = 1'b0;
    logic       e_err = 1'b0;

    always #2.5 clk = ~clk;

    audio_ratio_checker u0 (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .frame_clk_i    (frame_clk),
        .speed_sel_i    (speed),
        .half_rate_i    (half),
        .ratio_code_o   (code),
        .ratio_stable_o (stable),
        .ratio_err_o    (err),
        .clk_div_en_o   (div_en)
    );

    function automatic logic [2:0] golden(int n, logic [1:0] sp, logic h);
        int base;
        int top;
        int mult[5] = '{2, 3, 4, 6, 8};
        if (sp == 2'd3) return 3'd7;
        base = (sp == 2'd0) ? 128 : 64;
        top  = (sp == 2'd2) ? 2 : 4;
        for (int i = 0; i <= top; i++) begin
            if (n == base * mult[i] && (i < top || h)) return 3'(i);
        end
        return 3'd7;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_clk = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset code/stable/err/div", {code, stable, err, div_en}, {3'd7, 3'b000});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {code, stable, err, div_en}, {3'd7, 2'b00, half});
        armed = 1'b0;
        have_prev = 1'b0;
        e_code = 3'd7;
        e_stable = 1'b0;
        e_err = 1'b0;
    endtask

    // Driver: one frame-clock period; pushes the expected verdict of its rising edge.
    task automatic frame(int len, int hi, string req);
        exp_t it;
        int n;
        if (armed) begin
            n = (last_len > 4096) ? 4096 : last_len;
            e_code   = golden(n, speed, half);
            e_stable = have_prev && (n == prev_n);
            e_err    = (e_code == 3'd7) || (have_prev && n != prev_n);
            prev_n   = n;
            have_prev = 1'b1;
        end
        armed = 1'b1;
        it.code = e_code;
        it.stable = e_stable;
        it.err = e_err;
        it.req = req;
        sb.push_back(it);
        frame_clk = 1'b1;
        repeat (hi) @(negedge clk);
        frame_clk = 1'b0;
        repeat (len - hi) @(negedge clk);
        last_len = len;
    endtask

    task automatic frames(int len, int cnt, string req);
        for (int k = 0; k < cnt; k++) frame(len, len / 2, req);
    endtask

    // Monitor: compares the verdict a few cycles after each rising edge.
    initial begin
        forever begin
            @(posedge frame_clk);
            repeat (4) @(negedge clk);
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(it.req, {code, stable, err}, {it.code, it.stable, it.err});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        speed = 2'd0;
        half = 1'b0;
        frames(256, 3, "R2 R6 single 256");
        frames(384, 3, "R7 R2 single 384");
        frames(512, 2, "R2 single 512");
        frames(768, 2, "R2 single 768");
        frames(1024, 3, "R5 single top without divide");
        half = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 divide enable high", {3'd0, div_en}, 4'd1);
        last_len = last_len + 2;
        frames(1024, 3, "R5 single top with divide");
        half = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 divide enable low", {3'd0, div_en}, 4'd0);
        last_len = last_len + 2;
        frames(300, 3, "R8 non-table ratio");
        for (int k = 0; k < 3; k++) frame(512, 5, "R12 short high time");
        for (int k = 0; k < 2; k++) frame(512, 500, "R12 long high time");
        speed = 2'd1;
        frames(128, 3, "R3 double 128");
        frames(192, 2, "R3 double 192");
        frames(256, 2, "R3 double 256");
        frames(384, 2, "R3 double 384");
        frames(512, 3, "R5 double top without divide");
        half = 1'b1;
        frames(512, 2, "R5 double top with divide");
        half = 1'b0;
        speed = 2'd2;
        frames(128, 3, "R4 quad 128");
        frames(192, 2, "R4 quad 192");
        frames(256, 2, "R5 quad top without divide");
        half = 1'b1;
        frames(256, 2, "R5 quad top with divide");
        frames(384, 2, "R4 quad 384 illegal");
        half = 1'b0;
        speed = 2'd3;
        frames(256, 3, "R9 reserved range");
        speed = 2'd0;
        frames(5000, 3, "R11 saturated period");
        frames(256, 2, "R11 recovery");
        do_reset();
        frames(512, 2, "R6 re-arm after reset");
        repeat (10) @(negedge clk);
        check("scoreboard drained", 4'(sb.size()), 4'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule